// File: doc/BRIEF.md
# Gated-Input Serial-to-Parallel Shift Register

This block is a chain of flip-flops that share one clock. The bit fed into the first stage is the logical AND of two serial data pins. On every rising clock edge, that gated bit enters stage 1 and each later stage copies the stage in front of it. The bit leaving the last stage is dropped. All stage contents drive the parallel output together.

The block can serve as a tapped delay line, because tap k repeats the gated input k edges later. It can also generate phase-shifted copies of a slow rectangular waveform, one copy per tap, each one clock period behind the previous one. Either serial pin can act as an enable for the other.

An active-low clear input empties the whole chain at once, whatever the clock is doing.

Top module: `gated_sipo_shifter`

## Requirements
- R1: All `STAGES` stage values (default 8) appear together on `taps`. Bit 0 is stage 1, the stage nearest the serial input. Bit `STAGES-1` is the last stage.
- R2: The bit captured into stage 1 on a rising edge is `ser_a AND ser_b` as sampled at that edge. It is 1 only when both pins are 1.
- R3: On each rising edge with clear inactive, stage k (k ≥ 2) takes the value stage k-1 held just before that edge. The old value of the last stage is discarded.
- R4: Driving `clr_n` low sets every stage to 0 at once, with no clock edge needed.
- R5: While `clr_n` is low, rising clock edges change nothing, and every stage stays 0 whatever the serial pins are.
- R6: Shifting resumes on the very first rising edge after `clr_n` returns high. After that edge, stage 1 holds the gated bit and the other stages hold 0.
- R7: A single-cycle 1 on the gated input, after a clear, appears at tap k after exactly k rising edges and at no other tap.
- R8: A rectangular gated input that is slower than the clock appears at every tap as an unchanged copy of itself. Each tap's copy lags the copy at the tap before it by one clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low, overrides the clock |
| ser_a | input | 1 | Serial data pin, ANDed with `ser_b` |
| ser_b | input | 1 | Serial data pin, ANDed with `ser_a` |
| taps | output | STAGES | Parallel stage contents, bit 0 = stage 1 |

## Verification
The bench feeds a fixed table of pin pairs, then a long pseudo-random stream. It compares the whole tap vector against its own history of the gated bit. A design that OR-ed or XOR-ed the pins, or wired the stages in the wrong order, would diverge early.

Directed cases cover the following:
- A clear pulled low between edges must empty the chain before any edge arrives. A design with a synchronous clear would still show the old contents.
- Clock edges with both pins high during clear must leave everything at 0. A design that let the clock win would load ones.
- The first edge after release must shift. A design with an extra release stage would stay at 0 for one more edge.
- A lone pulse and a slow square wave confirm the one-edge spacing between taps.

// File: rtl/gsipo_pkg.sv
package gsipo_pkg;
  // Default length of the stage chain.
  localparam int unsigned GSIPO_STAGES_DEF = 8;
  // Number of serial pins combined into the entering bit.
  localparam int unsigned GSIPO_GATE_PINS  = 2;
  // Smallest chain that has both a head stage and a follower.
  localparam int unsigned GSIPO_STAGES_MIN = 2;
endpackage

// File: rtl/gsipo_gate.sv
// Combines the serial pins into the one bit that enters the chain.
module gsipo_gate #(
  parameter int unsigned PINS = gsipo_pkg::GSIPO_GATE_PINS
) (
  input  logic [PINS-1:0] pins,
  output logic            gated
);
  always_comb begin
    gated = &pins;
  end
endmodule

// File: rtl/gsipo_cell.sv
// One storage stage with an asynchronous active-low clear.
module gsipo_cell (
  input  logic clk,
  input  logic clr_n,
  input  logic d_in,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = d_in;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/gsipo_chain.sv
// Cascade of stages: stage 1 takes the entering bit, each later stage
// takes its predecessor.
module gsipo_chain #(
  parameter int unsigned STAGES = gsipo_pkg::GSIPO_STAGES_DEF
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              head_bit,
  output logic [STAGES-1:0] stage_q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[LAST-1:0], head_bit};
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    gsipo_cell u_cell (
      .clk   (clk),
      .clr_n (clr_n),
      .d_in  (stage_d[k]),
      .q     (stage_q[k])
    );
  end

  // Checker support: set by a clear, dropped by the next clock edge.
  logic clr_seen_q;
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) clr_seen_q <= 1'b1;
    else        clr_seen_q <= 1'b0;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_follow_chk
    // R3
    stage_follow_chk: assert property (@(posedge clk) disable iff (!clr_n)
      !clr_seen_q |-> stage_q[k] == $past(stage_q[k-1]));
  end
endmodule

// File: rtl/gated_sipo_shifter.sv
// Gated-input serial-to-parallel shift register.
module gated_sipo_shifter #(
  parameter int unsigned STAGES = gsipo_pkg::GSIPO_STAGES_DEF
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              ser_a,
  input  logic              ser_b,
  output logic [STAGES-1:0] taps
);
  localparam int unsigned PINS = gsipo_pkg::GSIPO_GATE_PINS;

  logic [PINS-1:0] pin_vec;
  logic            entry_bit;

  always_comb begin
    pin_vec = {ser_b, ser_a};
  end

  gsipo_gate #(.PINS(PINS)) u_gate (
    .pins  (pin_vec),
    .gated (entry_bit)
  );

  gsipo_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .clr_n    (clr_n),
    .head_bit (entry_bit),
    .stage_q  (taps)
  );

  // Checker support: set by a clear, dropped by the next clock edge.
  logic clr_seen_q;
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) clr_seen_q <= 1'b1;
    else        clr_seen_q <= 1'b0;
  end

  // R2
  head_and_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !clr_seen_q |-> taps[0] == $past(ser_a && ser_b));

  // R4
  clear_empty_chk: assert property (@(posedge clk)
    !clr_n |-> taps == '0);

  // R6
  release_start_chk: assert property (@(posedge clk)
    $rose(clr_n) |-> taps == '0);
endmodule

// File: tb/test_gated_sipo_shifter.sv
module test_gated_sipo_shifter;
  localparam int NS      = 8;
  localparam int NVEC    = 24;
  localparam int WD_CYC  = 5000;

  // Stimulus table: each entry is {ser_a, ser_b}.
  localparam logic [1:0] STIM [NVEC] = '{
    2'b11, 2'b00, 2'b11, 2'b11, 2'b01, 2'b10, 2'b11, 2'b00,
    2'b00, 2'b11, 2'b10, 2'b11, 2'b11, 2'b11, 2'b01, 2'b00,
    2'b11, 2'b10, 2'b01, 2'b11, 2'b00, 2'b11, 2'b11, 2'b10
  };

  logic clk = 1'b0;
  logic clr_n, ser_a, ser_b;
  logic [NS-1:0] taps;
  logic [NS-1:0] mdl;
  logic [NS-1:0] prev;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gated_sipo_shifter #(.STAGES(NS)) i_gated_sipo_shifter (
    .clk   (clk),
    .clr_n (clr_n),
    .ser_a (ser_a),
    .ser_b (ser_b),
    .taps  (taps)
  );

  task automatic check(input string req, input logic [NS-1:0] act,
                       input logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive pins after a falling edge, take one rising edge, compare at the
  // following falling edge.
  task automatic cycle(input logic a, input logic b, input string req);
    ser_a = a;
    ser_b = b;
    @(posedge clk);
    if (clr_n) mdl = {mdl[NS-2:0], a & b};
    @(negedge clk);
    check(req, taps, mdl);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr_n = 1'b0;
    mdl   = '0;
    @(negedge clk);
    clr_n = 1'b1;
  endtask

  initial begin
    #(WD_CYC * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    clr_n = 1'b1;
    ser_a = 1'b0;
    ser_b = 1'b0;
    mdl   = '0;
    #1 clr_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 reset state", taps, '0);
    clr_n = 1'b1;

    // Table walk, R1 R3 on the full vector, R2 on stage 1.
    for (int i = 0; i < NVEC; i++) begin
      cycle(STIM[i][1], STIM[i][0], "R3 table");
      check("R2 stage1", {{(NS-1){1'b0}}, taps[0]},
            {{(NS-1){1'b0}}, STIM[i][1] & STIM[i][0]});
    end

    // Pseudo-random streams against the history model (R1).
    for (int i = 0; i < 64; i++) begin
      logic [31:0] r;
      r = $urandom;
      cycle(r[0] | r[2], r[1] | r[3], "R1 random");
    end

    // AND truth table at stage 1 (R2).
    cycle(1'b0, 1'b1, "R2 01");
    cycle(1'b1, 1'b0, "R2 10");
    cycle(1'b0, 1'b0, "R2 00");
    cycle(1'b1, 1'b1, "R2 11");

    // Single pulse walks one tap per edge (R7).
    do_clear();
    cycle(1'b1, 1'b1, "R7 tap1");
    for (int k = 2; k <= NS; k++) begin
      cycle(1'b0, 1'b1, "R7 walk");
      check("R7 onehot", taps, NS'(1) << (k - 1));
    end
    cycle(1'b0, 1'b0, "R7 exit");
    check("R7 drained", taps, '0);

    // Fill with ones, then clear between edges (R4).
    for (int i = 0; i < NS; i++) cycle(1'b1, 1'b1, "R3 fill");
    check("R3 full", taps, '1);
    @(negedge clk);
    #1 clr_n = 1'b0;
    mdl = '0;
    #0.5 check("R4 async", taps, '0);

    // Edges during clear with both pins high (R5).
    ser_a = 1'b1;
    ser_b = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R5 held", taps, '0);
    end

    // First edge after release shifts (R6).
    clr_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R6 first edge", taps, NS'(1));
    mdl = NS'(1);

    // Slow square wave, period 6 clocks (R8).
    do_clear();
    for (int t = 0; t < 30; t++) begin
      prev = taps;
      cycle((t % 6) < 3, 1'b1, "R8 wave");
      check("R8 lag", taps[NS-1:1] & {(NS-1){1'b1}},
            prev[NS-2:0]);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule